// File: doc/BRIEF.md
# Multi-Device Serial Peripheral Master

This block is a byte-wide serial peripheral master that serves several slave chips from one shift engine. Software programs a 16-bit control word and then writes a data byte. The block sends that byte on MOSI, most significant bit first, in SPI mode 0. At the same time it collects the byte returned on the MISO line of the selected slave. A select field in the control word picks which chip-select goes low. Slot 0 is meant for a power-management chip and slot 1 for a firmware flash. A hold flag keeps that chip-select low between bytes, so a multi-byte command stays framed.

The control word also holds an enable bit, an interrupt enable, a request for a 16-bit transfer mode and a clock divider code. The 16-bit mode is not supported. Its bit is only reported on a flag pin, and transfers stay 8 bits wide. Bit 7 of the control word reads back as a busy indication and cannot be written.

The bus side is simple. There is one write strobe, an address bit that selects the control or data register, and a wide flag for 32-bit accesses to the control address. A wide access moves the received byte together with the control word.

The shift engine is a four-state machine:
- IDLE goes to LOW on an accepted data write.
- LOW is the clock-low half-period. It goes to HIGH at the end of its half-period and samples MISO on that step.
- HIGH is the clock-high half-period. At the end of its half-period it goes back to LOW and shifts MOSI, or, after the eighth bit, it goes to DONE.
- DONE lasts one cycle and returns to IDLE.

Top module: `spi_multi_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000. A control write stores only the bits under mask 0xCF03. Bit 7 is never taken from the written value and reads as busy.
- R2: Busy (control bit 7) is 1 for exactly 16·H+1 cycles after the clock edge that accepts a data write. H = DIV_UNIT << ctl[1:0], so the default codes 0..3 give 17, 33, 65 and 129 cycles.
- R3: MOSI carries the data byte MSB first in SPI mode 0. SCK idles low, MISO is sampled when SCK rises, and MOSI changes only while SCK is low. After the transfer, the data register reads the 8 bits returned by the slave.
- R4: The select field ctl[9:8] routes the transfer: code 0 drives cs_n[0] low and code 1 drives cs_n[1] low. At most one chip-select is low at any time.
- R5: With select codes 2 or 3, data writes are discarded: busy stays 0 and no chip-select goes low. The data register then reads 0.
- R6: While ctl[15] (enable) is 0, data writes are ignored and the data register reads 0. The last received byte is kept and reads back once enable is set again.
- R7: When ctl[11] (hold) is set for a byte, its chip-select stays low after the byte ends. A byte sent with hold clear releases the chip-select as the engine returns to idle.
- R8: When ctl[14] is set, irq pulses high for exactly one cycle at the end of each byte, in the cycle before busy falls. When ctl[14] is clear, irq stays low.
- R9: ctl[10] is shown on mode16_flag. With it set, the transfer stays 8 bits long with the same busy length.
- R10: A wide read at the control address returns {8'h00, data byte, control word}. A wide write there stores bits 15:0 as control, then writes bits 23:16 as data under the new control. A data-address write uses only bits 7:0.
- R11: A data write that arrives while busy is ignored. It neither restarts nor lengthens the byte in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control word, 1 = data byte |
| bus_wide | input | 1 | 32-bit access at the control address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and bus_wide |
| irq | output | 1 | Byte-complete interrupt pulse |
| mode16_flag | output | 1 | 16-bit mode requested, which is not supported |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | NUM_DEV | Serial data in, one line per slave |
| cs_n | output | NUM_DEV | Active-low chip-selects, one per slave |

## Verification
Control-word changes show up in the read value one cycle after the write edge. A data write raises busy one cycle after its edge. Busy then stays high for 16·H+1 cycles. irq is high in the last of those cycles, and the chip-select is released in the cycle after irq.

The bench drives inputs and samples outputs at falling clock edges. It measures the busy length by counting falling edges at which bit 7 is high. It checks the received byte, the byte captured by the slave model, the irq count and the chip-select state only once busy has fallen. Ignored-write cases are checked at the first falling edge after the write, where a start would already be visible.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } shift_state_e;

    localparam logic [15:0] CTL_WMASK = 16'hCF03;
    localparam int CTL_EN   = 15;
    localparam int CTL_IRQ  = 14;
    localparam int CTL_HOLD = 11;
    localparam int CTL_W16  = 10;
    localparam int CTL_BUSY = 7;
    localparam int SEL_W    = 2;

endpackage

// File: rtl/spi_mc_ctlreg.sv
module spi_mc_ctlreg
    import spi_mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [15:0]      wdata,
    output logic [15:0]      ctl_q,
    output logic             view_en,
    output logic [SEL_W-1:0] view_sel,
    output logic [1:0]       view_div,
    output logic             view_hold
);
    logic [15:0] masked;
    logic [15:0] view;

    assign masked = wdata & CTL_WMASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr)
            ctl_q <= masked;
    end

    // control in effect for a data write in the same access
    assign view      = wr ? masked : ctl_q;
    assign view_en   = view[CTL_EN];
    assign view_sel  = view[9:8];
    assign view_div  = view[1:0];
    assign view_hold = view[CTL_HOLD];

endmodule

// File: rtl/spi_mc_engine.sv
module spi_mc_engine
    import spi_mc_pkg::*;
#(
    parameter int DIV_UNIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic [1:0] div_code,
    input  logic       hold_in,
    input  logic       miso_bit,
    output logic       busy,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       cs_active
);
    localparam int MAXH  = DIV_UNIT << 3;
    localparam int CNT_W = ($clog2(MAXH) < 1) ? 1 : $clog2(MAXH);

    shift_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic [2:0]       bit_q;
    logic [1:0]       div_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_sh_q;
    logic             hold_q;
    logic             held_q;
    logic             last_half;

    assign half_m1   = CNT_W'((DIV_UNIT << div_q) - 1);
    assign last_half = (cnt_q == half_m1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (last_half) state_d = ST_HIGH;
            ST_HIGH: if (last_half) state_d = (bit_q == 3'd7) ? ST_DONE : ST_LOW;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            div_q   <= '0;
            tx_q    <= '0;
            rx_sh_q <= '0;
            rx_byte <= '0;
            hold_q  <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            if ((state_q == ST_LOW || state_q == ST_HIGH) && !last_half)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    tx_q   <= tx_byte;
                    bit_q  <= '0;
                    div_q  <= div_code;
                    hold_q <= hold_in;
                end
                ST_LOW: if (last_half)
                    rx_sh_q <= {rx_sh_q[6:0], miso_bit};
                ST_HIGH: if (last_half) begin
                    tx_q  <= {tx_q[6:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == 3'd7) rx_byte <= rx_sh_q;
                end
                ST_DONE: held_q <= hold_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        sck       = (state_q == ST_HIGH);
        mosi      = (state_q == ST_LOW || state_q == ST_HIGH) ? tx_q[7] : 1'b0;
        done      = (state_q == ST_DONE);
        cs_active = busy || held_q;
    end

endmodule

// File: rtl/spi_mc_route.sv
module spi_mc_route
    import spi_mc_pkg::*;
#(
    parameter int NUM_DEV = 2
) (
    input  logic               cs_active,
    input  logic [SEL_W-1:0]   sel_held,
    input  logic [NUM_DEV-1:0] miso,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               miso_bit
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
        assign cs_n[i] = ~(cs_active && (sel_held == SEL_W'(i)));
    end

    always_comb begin
        miso_bit = 1'b0;
        for (int i = 0; i < NUM_DEV; i++)
            if (sel_held == SEL_W'(i)) miso_bit = miso[i];
    end

endmodule

// File: rtl/spi_multi_ctrl.sv
module spi_multi_ctrl
    import spi_mc_pkg::*;
#(
    parameter int NUM_DEV  = 2,
    parameter int DIV_UNIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic               bus_wide,
    input  logic [23:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               mode16_flag,
    output logic               sck,
    output logic               mosi,
    input  logic [NUM_DEV-1:0] miso,
    output logic [NUM_DEV-1:0] cs_n
);
    localparam logic [SEL_W:0] DEV_LIMIT = (SEL_W + 1)'(NUM_DEV);

    logic [15:0]      ctl_q;
    logic             view_en, view_hold;
    logic [SEL_W-1:0] view_sel;
    logic [1:0]       view_div;
    logic             ctl_wr, data_wr, start;
    logic [7:0]       data_byte;
    logic             eng_busy, eng_done, cs_active, miso_bit;
    logic [7:0]       rx_byte;
    logic [SEL_W-1:0] sel_held;
    logic             rd_ok;
    logic [7:0]       data_rd;
    logic [15:0]      ctl_rd;

    assign ctl_wr    = bus_wr && !bus_addr;
    assign data_wr   = bus_wr && (bus_addr || bus_wide);
    assign data_byte = bus_addr ? bus_wdata[7:0] : bus_wdata[23:16];

    spi_mc_ctlreg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .wdata     (bus_wdata[15:0]),
        .ctl_q     (ctl_q),
        .view_en   (view_en),
        .view_sel  (view_sel),
        .view_div  (view_div),
        .view_hold (view_hold)
    );

    assign start = data_wr && view_en && ({1'b0, view_sel} < DEV_LIMIT) && !eng_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_held <= '0;
        else if (start) sel_held <= view_sel;
    end

    spi_mc_engine #(.DIV_UNIT(DIV_UNIT)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_byte   (data_byte),
        .div_code  (view_div),
        .hold_in   (view_hold),
        .miso_bit  (miso_bit),
        .busy      (eng_busy),
        .sck       (sck),
        .mosi      (mosi),
        .done      (eng_done),
        .rx_byte   (rx_byte),
        .cs_active (cs_active)
    );

    spi_mc_route #(.NUM_DEV(NUM_DEV)) u_route (
        .cs_active (cs_active),
        .sel_held  (sel_held),
        .miso      (miso),
        .cs_n      (cs_n),
        .miso_bit  (miso_bit)
    );

    assign rd_ok   = ctl_q[CTL_EN] && ({1'b0, ctl_q[9:8]} < DEV_LIMIT);
    assign data_rd = rd_ok ? rx_byte : 8'h00;
    assign ctl_rd  = ctl_q | (16'(eng_busy) << CTL_BUSY);

    always_comb begin
        if (bus_addr)      bus_rdata = {24'h0, data_rd};
        else if (bus_wide) bus_rdata = {8'h0, data_rd, ctl_rd};
        else               bus_rdata = {16'h0, ctl_rd};
    end

    assign irq         = eng_done && ctl_q[CTL_IRQ];
    assign mode16_flag = ctl_q[CTL_W16];

endmodule

// File: rtl/spi_mc_checker.sv
module spi_mc_checker #(
    parameter int NUM_DEV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               irq,
    input logic               sck,
    input logic               mosi,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               bus_wr,
    input logic               bus_addr,
    input logic               ctl_en
);
    p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_cs_during_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(&cs_n));

    p_idle_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !mosi));

    p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy);

    p_disabled_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !ctl_en && !busy) |=> !busy);

endmodule

bind spi_multi_ctrl spi_mc_checker #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .irq      (irq),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctl_en   (ctl_q[15])
);

// File: tb/tb_spi_multi_ctrl.sv
module tb_spi_multi_ctrl;
    localparam int NDEV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_addr = 1'b0, bus_wide = 1'b0;
    logic [23:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, mode16_flag, sck, mosi;
    logic [NDEV-1:0] miso, cs_n;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;

    spi_multi_ctrl #(.NUM_DEV(NDEV), .DIV_UNIT(1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .mode16_flag(mode16_flag), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    // slave models: fixed reply byte, capture of MOSI on rising SCK
    localparam logic [7:0] RESP0 = 8'hA5;
    localparam logic [7:0] RESP1 = 8'h5E;
    logic [7:0] slv_rx [NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_slv
        logic [2:0] cnt = 3'd0;
        logic [7:0] resp;
        assign resp = (g == 0) ? RESP0 : RESP1;
        assign miso[g] = resp[3'd7 - cnt];
        always @(posedge sck or posedge cs_n[g]) begin
            if (cs_n[g]) cnt <= 3'd0;
            else begin
                cnt <= cnt + 3'd1;
                slv_rx[g] <= {slv_rx[g][6:0], mosi};
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic wide, input logic [23:0] d);
        @(negedge clk);
        bus_addr = a; bus_wide = wide; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic wide, output logic [31:0] v);
        bus_addr = a; bus_wide = wide;
        #1 v = bus_rdata;
        bus_addr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic wait_idle(output int n, output logic [NDEV-1:0] cs_first);
        n = 0;
        bus_addr = 1'b0; bus_wide = 1'b0;
        #1 cs_first = cs_n;
        while (bus_rdata[7] && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    // {ctl, tx byte, expected rx, expected busy cycles}
    localparam logic [39:0] VEC [5] = '{
        {16'hC000, 8'h96, RESP0, 8'd17},
        {16'h8101, 8'h3C, RESP1, 8'd33},
        {16'hC002, 8'hF0, RESP0, 8'd65},
        {16'h8103, 8'h01, RESP1, 8'd129},
        {16'hC500, 8'h7E, RESP1, 8'd17}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, i0;
        logic [NDEV-1:0] csf;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1)
        rd(1'b0, 1'b1, v);
        chk(v == 32'h0, "R1 reset readback", v, 0);
        chk(cs_n == 2'b11 && !sck && !irq, "R4 reset lines idle", {cs_n, sck, irq}, 32'hC);

        // vector table: R2 R3 R4 R8 R9
        for (int k = 0; k < 5; k++) begin
            logic [15:0] c; logic [7:0] tx, erx, ecyc;
            {c, tx, erx, ecyc} = VEC[k];
            wr(1'b0, 1'b0, {8'h0, c});
            chk(mode16_flag == c[10], "R9 mode16 flag", mode16_flag, c[10]);
            i0 = irq_cnt;
            wr(1'b1, 1'b0, {16'h0, tx});
            wait_idle(n, csf);
            chk(n == int'(ecyc), "R2 busy length", n, ecyc);
            chk(csf == ~(2'b01 << c[8]), "R4 chip-select routing", csf, ~(2'b01 << c[8]));
            rd(1'b1, 1'b0, v);
            chk(v[7:0] == erx, "R3 received byte", v, erx);
            chk(slv_rx[c[8]] == tx, "R3 MOSI byte at slave", slv_rx[c[8]], tx);
            chk(irq_cnt - i0 == (c[14] ? 1 : 0), "R8 irq pulses", irq_cnt - i0, c[14]);
            chk(cs_n == 2'b11, "R7 release without hold", cs_n, 2'b11);
        end

        // R1 write mask, busy bit not writable
        wr(1'b0, 1'b0, 24'h00FFFF);
        rd(1'b0, 1'b0, v);
        chk(v == 32'hCF03, "R1 control mask", v, 32'hCF03);

        // R5 invalid device code
        wr(1'b0, 1'b0, 24'h008200);
        wr(1'b1, 1'b0, 24'h000011);
        rd(1'b0, 1'b0, v);
        chk(v[7] == 1'b0 && cs_n == 2'b11, "R5 no start on code 2", {v[7], cs_n}, 32'h3);
        rd(1'b1, 1'b0, v);
        chk(v == 32'h0, "R5 data read zero", v, 0);

        // R6 enable clear
        wr(1'b0, 1'b0, 24'h000100);
        wr(1'b1, 1'b0, 24'h000022);
        rd(1'b0, 1'b0, v);
        chk(v[7] == 1'b0 && cs_n == 2'b11, "R6 disabled write ignored", {v[7], cs_n}, 32'h3);
        rd(1'b1, 1'b0, v);
        chk(v == 32'h0, "R6 disabled read zero", v, 0);
        wr(1'b0, 1'b0, 24'h008100);
        rd(1'b1, 1'b0, v);
        chk(v[7:0] == RESP1, "R6 rx byte kept", v, RESP1);

        // R7 hold across bytes
        wr(1'b0, 1'b0, 24'h008800);
        wr(1'b1, 1'b0, 24'h000012);
        wait_idle(n, csf);
        chk(cs_n == 2'b10, "R7 held after byte 1", cs_n, 2'b10);
        wr(1'b1, 1'b0, 24'h000034);
        wait_idle(n, csf);
        chk(cs_n == 2'b10 && slv_rx[0] == 8'h34, "R7 held after byte 2", {cs_n, slv_rx[0]}, {2'b10, 8'h34});
        wr(1'b0, 1'b0, 24'h008000);
        wr(1'b1, 1'b0, 24'h000056);
        wait_idle(n, csf);
        chk(cs_n == 2'b11 && slv_rx[0] == 8'h56, "R7 released by last byte", {cs_n, slv_rx[0]}, {2'b11, 8'h56});

        // R11 write during busy
        wr(1'b0, 1'b0, 24'h008003);
        wr(1'b1, 1'b0, 24'h0000A1);
        wr(1'b1, 1'b0, 24'h0000B2);
        wait_idle(n, csf);
        chk(n + 2 == 129, "R11 busy not extended", n + 2, 129);
        chk(slv_rx[0] == 8'hA1, "R11 first byte kept", slv_rx[0], 8'hA1);

        // R10 wide write then wide read
        i0 = irq_cnt;
        wr(1'b0, 1'b1, 24'h5AC001);
        wait_idle(n, csf);
        chk(n == 33 && slv_rx[0] == 8'h5A, "R10 wide write starts byte", {n[7:0], slv_rx[0]}, {8'd33, 8'h5A});
        chk(irq_cnt - i0 == 1, "R8 irq on wide write", irq_cnt - i0, 1);
        rd(1'b0, 1'b1, v);
        chk(v == {8'h00, RESP0, 16'hC001}, "R10 wide read", v, {8'h00, RESP0, 16'hC001});

        // R10 data write uses low byte only
        wr(1'b0, 1'b0, 24'h008000);
        wr(1'b1, 1'b0, 24'hFFFF3C);
        wait_idle(n, csf);
        chk(slv_rx[0] == 8'h3C, "R10 low byte only", slv_rx[0], 8'h3C);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule